// File: doc/BRIEF.md
# Protected Runtime Clock Prescaler

This block divides a master clock by a power of two picked by software at run time. The ratio sits in an 8-bit control register, and writes to it are guarded. A write of exactly 0x80 arms a short change window. Only a write made while that window is open may load a new ratio. The guard stops a stray store from changing the clock speed of the whole system.

The block produces a one-cycle enable pulse at the end of every divided period. It also produces a divided clock level, which can be routed to an output pin in place of that pin's normal signal. A configuration input chooses whether reset leaves the divider at divide-by-1 or divide-by-8. A new ratio is applied only at a period boundary, so the output never carries a shortened pulse.

Top module: `rtclk_prescaler`

## Requirements
- R1: The read value is {window_open, 3'b000, ratio_code[3:0]}: bit 7 shows whether the window is open, bits 6:4 always read zero, and bits 3:0 hold the stored ratio code.
- R2: The window opens only on a write of exactly 8'h80. A write with bit 7 set and any other bit set does not open it.
- R3: An opened window stays open for exactly the four clock cycles that follow the opening write, then closes by itself.
- R4: Writing 8'h80 again while the window is open neither closes it nor lengthens it.
- R5: A write with bit 7 clear while the window is open is a ratio write, and it closes the window in the next cycle.
- R6: Writes made while the window is closed leave the ratio code unchanged.
- R7: A ratio write of a reserved code (9 to 15) keeps the previous code, but still closes the window.
- R8: A code c from 0 to 8 divides by 2^c. div_en pulses once every 2^c master cycles, in the last cycle of each period.
- R9: Reset clears the window. The ratio code resets to 3 when cfg_div8 is high and to 0 when it is low.
- R10: A new code takes effect only after the current divided period has finished. The first new period starts in the cycle after the div_en pulse.
- R11: When cfg_clk_out is high, pin_out carries the divided clock: low in the first half of each period and high in the second, or the master clock at divide-by-1. pin_out is held low while reset is asserted. When cfg_clk_out is low, pin_out follows pin_gpio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div8 | input | 1 | Selects divide-by-8 as the reset ratio |
| cfg_clk_out | input | 1 | Routes the divided clock to pin_out |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| pin_gpio | input | 1 | Normal pin signal |
| div_en | output | 1 | One-cycle pulse at the end of each divided period |
| pin_out | output | 1 | Pin output: divided clock or pin_gpio |

## Verification
A ratio write can land in the same cycle in which the open window would time out. The bench provokes this by issuing the select write in the fourth cycle after the unlock, and it expects the new code to be accepted. In a second case, extra unlock writes fall in cycles two and three and the select write comes one cycle too late; there the code must stay unchanged. A ratio load can also land in the same cycle as a div_en pulse. The bench judges both collisions against a behavioural model that it compares with the design on every clock.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
    localparam int CKP_REG_W    = 8;
    localparam int CKP_SEL_W    = 4;
    localparam int CKP_MAX_CODE = 8;
    localparam int CKP_WIN      = 4;
    localparam int CKP_WIN_W    = $clog2(CKP_WIN);
    localparam int CKP_CNT_W    = CKP_MAX_CODE;
    localparam int CKP_DIV8_CODE = 3;
    localparam logic [CKP_REG_W-1:0] CKP_UNLOCK_PAT = 8'h80;

    typedef struct packed {
        logic                 open;
        logic [CKP_WIN_W-1:0] wcnt;
        logic [CKP_SEL_W-1:0] sel;
    } ckp_win_t;

    typedef struct packed {
        logic [CKP_CNT_W-1:0] cnt;
        logic [CKP_SEL_W-1:0] act;
    } ckp_div_t;
endpackage

// File: rtl/ckp_guard.sv
module ckp_guard
    import ckp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_div8,
    input  logic                 wr_en,
    input  logic [CKP_REG_W-1:0] wr_data,
    output logic                 win_open,
    output logic [CKP_SEL_W-1:0] sel_code
);
    ckp_win_t st_d, st_q;
    logic     pat_hit;
    logic     sel_wr;

    always_comb begin
        st_d    = st_q;
        pat_hit = wr_en && (wr_data == CKP_UNLOCK_PAT);
        sel_wr  = wr_en && st_q.open && !wr_data[CKP_REG_W-1];
        if (sel_wr) begin
            st_d.open = 1'b0;
            st_d.wcnt = '0;
            if (wr_data[CKP_SEL_W-1:0] <= CKP_SEL_W'(CKP_MAX_CODE))
                st_d.sel = wr_data[CKP_SEL_W-1:0];
        end else if (st_q.open) begin
            if (st_q.wcnt == '0)
                st_d.open = 1'b0;
            else
                st_d.wcnt = st_q.wcnt - 1'b1;
        end else if (pat_hit) begin
            st_d.open = 1'b1;
            st_d.wcnt = CKP_WIN_W'(CKP_WIN - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.open <= 1'b0;
            st_q.wcnt <= '0;
            st_q.sel  <= cfg_div8 ? CKP_SEL_W'(CKP_DIV8_CODE) : '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_open = st_q.open;
    assign sel_code = st_q.sel;

    assert_open_by_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> $past(wr_en && wr_data == CKP_UNLOCK_PAT));

    assert_window_expires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && st_q.wcnt == '0) |=> !st_q.open);

    assert_no_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && st_q.wcnt != '0 && wr_en && wr_data == CKP_UNLOCK_PAT)
        |=> (st_q.open && st_q.wcnt == CKP_WIN_W'($past(st_q.wcnt) - 1'b1)));

    assert_close_on_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && wr_en && !wr_data[CKP_REG_W-1]) |=> !st_q.open);

    assert_locked_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.open |=> $stable(st_q.sel));

    assert_reserved_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && wr_en && !wr_data[CKP_REG_W-1]
         && wr_data[CKP_SEL_W-1:0] > CKP_SEL_W'(CKP_MAX_CODE))
        |=> ($stable(st_q.sel) && !st_q.open));
endmodule

// File: rtl/ckp_divider.sv
module ckp_divider
    import ckp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_div8,
    input  logic [CKP_SEL_W-1:0] sel_code,
    output logic                 tick,
    output logic                 clk_lvl
);
    localparam int IDX_W = $clog2(CKP_CNT_W);

    ckp_div_t           dv_d, dv_q;
    logic [CKP_CNT_W:0] span;
    logic [CKP_CNT_W-1:0] last;
    logic [IDX_W-1:0]   msb_idx;

    always_comb begin
        span    = (CKP_CNT_W+1)'(1) << dv_q.act;
        last    = CKP_CNT_W'(span - 1'b1);
        tick    = (dv_q.cnt == last);
        msb_idx = IDX_W'(dv_q.act - 1'b1);
        dv_d    = dv_q;
        if (tick) begin
            dv_d.cnt = '0;
            dv_d.act = sel_code;
        end else begin
            dv_d.cnt = dv_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q.cnt <= '0;
            dv_q.act <= cfg_div8 ? CKP_SEL_W'(CKP_DIV8_CODE) : '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign clk_lvl = (dv_q.act == '0) ? clk : dv_q.cnt[msb_idx];

    assert_switch_on_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dv_q.act));

    assert_legal_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.act <= CKP_SEL_W'(CKP_MAX_CODE));
endmodule

// File: rtl/rtclk_prescaler.sv
module rtclk_prescaler
    import ckp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_div8,
    input  logic       cfg_clk_out,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       pin_gpio,
    output logic       div_en,
    output logic       pin_out
);
    logic                 win_open;
    logic [CKP_SEL_W-1:0] sel_code;
    logic                 clk_lvl;

    ckp_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_div8 (cfg_div8),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .win_open (win_open),
        .sel_code (sel_code)
    );

    ckp_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_div8 (cfg_div8),
        .sel_code (sel_code),
        .tick     (div_en),
        .clk_lvl  (clk_lvl)
    );

    assign rd_data = {win_open, {(CKP_REG_W-CKP_SEL_W-1){1'b0}}, sel_code};
    assign pin_out = cfg_clk_out ? (rst_n & clk_lvl) : pin_gpio;
endmodule

// File: tb/tb_rtclk_prescaler.sv
module tb_rtclk_prescaler;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_div8 = 1'b1;
    logic       cfg_clk_out = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pin_gpio = 1'b0;
    logic [7:0] rd_data;
    logic       div_en;
    logic       pin_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int m_open, m_left, m_sel, m_act, m_cnt;

    rtclk_prescaler dut (
        .clk(clk), .rst_n(rst_n), .cfg_div8(cfg_div8), .cfg_clk_out(cfg_clk_out),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pin_gpio(pin_gpio), .div_en(div_en), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_open = 0; m_left = 0;
            m_sel  = cfg_div8 ? 3 : 0;
            m_act  = m_sel; m_cnt = 0;
        end else begin
            if (m_cnt == (1 << m_act) - 1) begin
                m_cnt = 0; m_act = m_sel;
            end else begin
                m_cnt++;
            end
            if (wr_en && m_open == 1 && wr_data[7] == 1'b0) begin
                m_open = 0;
                if (wr_data[3:0] <= 8) m_sel = int'(wr_data[3:0]);
            end else if (m_open == 1) begin
                m_left--;
                if (m_left == 0) m_open = 0;
            end else if (wr_en && wr_data == 8'h80) begin
                m_open = 1; m_left = 4;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            if (cfg_clk_out) check("R11 pin low in reset", int'(pin_out), 0);
        end else begin
            check("R1 R2 R3 R4 R5 R6 R7 rd_data", int'(rd_data), (m_open << 7) | m_sel);
            check("R8 R10 div_en", int'(div_en), (m_cnt == (1 << m_act) - 1) ? 1 : 0);
            if (cfg_clk_out)
                check("R11 clock on pin", int'(pin_out), (m_act == 0) ? 0 : ((m_cnt >> (m_act - 1)) & 1));
            else
                check("R11 gpio on pin", int'(pin_out), int'(pin_gpio));
        end
    end

    task automatic cyc(input logic en, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = en; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle(3);
        check("R9 reset code div8", int'(rd_data), 8'h03);
        @(negedge clk); #1 rst_n = 1'b1;
        idle(40);
        // R2: near-miss pattern must not open
        cyc(1, 8'h81); idle(2);
        cyc(1, 8'h02); idle(20);
        // R5: open then select code 0 two cycles later
        cyc(1, 8'h80); idle(1); cyc(1, 8'h00); idle(12);
        // R3 R6: select write one cycle after the window closed
        cyc(1, 8'h80); idle(4); cyc(1, 8'h02); idle(10);
        // R4: repeated unlock, select in last open cycle is accepted
        cyc(1, 8'h80); cyc(1, 8'h80); cyc(1, 8'h80); idle(1); cyc(1, 8'h05); idle(140);
        // R4: repeated unlock, select one cycle late is rejected
        cyc(1, 8'h80); cyc(1, 8'h80); cyc(1, 8'h80); idle(2); cyc(1, 8'h01); idle(80);
        // R2: bit 7 with other bits inside window neither selects nor closes
        cyc(1, 8'h80); cyc(1, 8'h85); cyc(1, 8'h02); idle(30);
        // R7: reserved code in window
        cyc(1, 8'h80); cyc(1, 8'h0C); idle(30);
        // R8: largest ratio
        cyc(1, 8'h80); cyc(1, 8'h08); idle(700);
        // R10: change ratio repeatedly at arbitrary phases
        for (int k = 0; k < 9; k++) begin
            cyc(1, 8'h80); idle(k % 3); cyc(1, 8'(k)); idle(37 + k * 5);
        end
        // R11: gpio mode
        cfg_clk_out = 1'b0;
        for (int k = 0; k < 20; k++) begin
            cyc(0, 8'h00); pin_gpio = k[0] ^ k[2];
        end
        cfg_clk_out = 1'b1;
        // R9: reset with divide-by-1 default
        @(negedge clk); #1 rst_n = 1'b0; cfg_div8 = 1'b0;
        idle(3);
        check("R9 reset code div1", int'(rd_data), 8'h00);
        @(negedge clk); #1 rst_n = 1'b1;
        idle(20);
        cyc(1, 8'h80); cyc(1, 8'h01); idle(30);
        finish_run();
    end
endmodule